// File: doc/BRIEF.md
# Exception Delivery and Privileged-Mode Entry Controller

This block takes one pending exception request at a time and decides when it may be taken. A request is a one-cycle pulse that carries a 2-bit reason code, a vector, the PC of the faulting instruction, a call function code, an arithmetic flag and a summary value. The block captures these into its own holding registers and keeps them until four conditions all hold: no event of higher priority is waiting, no barrier is active, the pipeline reports a safe state, and the faulting instruction has reached writeback.

When the request is taken, the block runs the privileged-mode entry in one commit cycle. In that cycle it raises the context-save strobe and writes the exception-address register with the faulting PC. It writes the new PC, sets the interrupt priority level to 7 and the mode to kernel. It also enables the shadow registers for explicit privileged calls, writes the exception summary for arithmetic traps, and pulses the pipeline flush. The new PC is the entry target with bit 0 forced to 1, which marks privileged execution. For an explicit call, the entry target is the privileged-code base plus the function code shifted left by 6. For every other reason, the entry target is the supplied vector.

The controller is a three-state machine. In IDLE it waits, and a request pulse moves it from IDLE to HOLD (request captured). It stays in HOLD while any delivery condition fails, and moves from HOLD to ENTER once all four conditions hold. ENTER is the single commit cycle, and it always returns to IDLE.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, every strobe and write enable is low and no request is held.
- R2: A held request is committed only in the cycle after a cycle in which all four conditions hold (`hi_pri_pending`=0, `barrier_active`=0, `pipe_safe`=1, `at_writeback`=1). Every accepted request is committed exactly once.
- R3: While any condition fails, the held request stays pending, with no strobe or write enable raised and its captured fields unchanged. A new request pulse that arrives while a request is held or being committed is ignored.
- R4: Reason code 2'b00 (privileged call) gives an entry target of `priv_base` + (`req_func` << 6).
- R5: Reason codes 2'b01 (trap), 2'b10 (interrupt) and 2'b11 (fault) use `req_vector` as the entry target. For every reason, `pc_wdata` is the entry target with bit 0 set to 1.
- R6: `exc_addr_wdata` equals the faulting PC of the committed request.
- R7: On commit, `ipl_wdata` is 7 and `mode_wdata` is 2'b00 (kernel).
- R8: `shadow_set` is raised on commit only for reason code 2'b00.
- R9: `exc_sum_we` is raised on commit only for reason code 2'b01 with `req_arith`=1, and then `exc_sum_wdata` equals `req_sum`.
- R10: `ctx_save` and `flush` are each high for exactly one cycle per delivery. All write enables are high in that same cycle and never outside it.
- R11: With all conditions already true, a request pulsed in cycle t commits in cycle t+2 (one cycle to capture, one to commit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle exception request pulse |
| req_reason | input | 2 | Reason: 00 call, 01 trap, 10 interrupt, 11 fault |
| req_vector | input | ADDR_W | Dispatch vector for non-call reasons |
| req_fault_pc | input | ADDR_W | PC of the faulting instruction |
| req_func | input | FUNC_W | Function code of a privileged call |
| req_arith | input | 1 | Trap is arithmetic |
| req_sum | input | SUM_W | Exception summary value |
| hi_pri_pending | input | 1 | A higher-priority event is waiting |
| barrier_active | input | 1 | A barrier blocks delivery |
| pipe_safe | input | 1 | Pipeline is in a safe state |
| at_writeback | input | 1 | Faulting instruction is in writeback |
| priv_base | input | ADDR_W | Base address of privileged code |
| ctx_save | output | 1 | Context-save strobe |
| exc_addr_we | output | 1 | Exception-address register write |
| exc_addr_wdata | output | ADDR_W | Exception-address write data |
| exc_sum_we | output | 1 | Exception-summary register write |
| exc_sum_wdata | output | SUM_W | Exception-summary write data |
| pc_we | output | 1 | PC write |
| pc_wdata | output | ADDR_W | New PC, bit 0 set |
| ipl_we | output | 1 | Priority level write |
| ipl_wdata | output | IPL_W | New priority level (7) |
| mode_we | output | 1 | Current mode write |
| mode_wdata | output | MODE_W | New mode (kernel, 00) |
| shadow_set | output | 1 | Enable shadow registers |
| flush | output | 1 | Pipeline flush pulse |

## Verification
When the conditions are already open, the commit comes two clock edges after the request pulse: the first edge captures the request and the second enters the commit state. When the conditions are blocked, the commit comes one edge after the cycle in which the last blocking condition clears. The driver writes the cycle number it expects into each scoreboard item, and the monitor samples on the falling edge and compares that number to the cycle in which `ctx_save` actually appears. During blocked cycles the driver also checks that no strobe is high, and it injects a second request, which must be ignored.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [1:0] {
        RSN_CALL  = 2'b00,
        RSN_TRAP  = 2'b01,
        RSN_INTR  = 2'b10,
        RSN_FAULT = 2'b11
    } reason_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_HOLD  = 2'b01,
        ST_ENTER = 2'b10
    } fsm_state_e;

    localparam int unsigned IPL_MASK_ALL = 7;
    localparam int unsigned MODE_KERNEL  = 0;

endpackage

// File: rtl/exc_gate.sv
module exc_gate (
    input  logic hi_pri_pending,
    input  logic barrier_active,
    input  logic pipe_safe,
    input  logic at_writeback,
    output logic gate_ok
);

    always_comb begin
        gate_ok = !hi_pri_pending && !barrier_active && pipe_safe && at_writeback;
    end

endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned FUNC_W    = 8,
    parameter int unsigned OFS_SHIFT = 6
) (
    input  reason_e             reason,
    input  logic [ADDR_W-1:0]   vector,
    input  logic [FUNC_W-1:0]   func,
    input  logic [ADDR_W-1:0]   base,
    output logic [ADDR_W-1:0]   marked_pc
);

    localparam int unsigned PAD_W = ADDR_W - FUNC_W;

    logic [ADDR_W-1:0] call_ofs;
    logic [ADDR_W-1:0] entry_pc;

    always_comb begin
        call_ofs = {{PAD_W{1'b0}}, func} << OFS_SHIFT;
        unique case (reason)
            RSN_CALL: entry_pc = base + call_ofs;
            default:  entry_pc = vector;
        endcase
        marked_pc = {entry_pc[ADDR_W-1:1], 1'b1};
    end

endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
    import exc_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic gate_ok,
    output logic capture,
    output logic enter,
    output logic pending
);

    fsm_state_e st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        unique case (st)
            ST_IDLE:  st_nx = req_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD:  st_nx = gate_ok ? ST_ENTER : ST_HOLD;
            ST_ENTER: st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        capture = (st == ST_IDLE) && req_valid;
        enter   = (st == ST_ENTER);
        pending = (st == ST_HOLD);
    end

    AST_ENTER_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ENTER) |-> $past(gate_ok)); // R2
    AST_ENTER_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> !enter); // R10
    AST_HOLD_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !gate_ok) |=> pending); // R3

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned FUNC_W    = 8,
    parameter int unsigned SUM_W     = 8,
    parameter int unsigned IPL_W     = 5,
    parameter int unsigned MODE_W    = 2,
    parameter int unsigned OFS_SHIFT = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_reason,
    input  logic [ADDR_W-1:0]   req_vector,
    input  logic [ADDR_W-1:0]   req_fault_pc,
    input  logic [FUNC_W-1:0]   req_func,
    input  logic                req_arith,
    input  logic [SUM_W-1:0]    req_sum,
    input  logic                hi_pri_pending,
    input  logic                barrier_active,
    input  logic                pipe_safe,
    input  logic                at_writeback,
    input  logic [ADDR_W-1:0]   priv_base,
    output logic                ctx_save,
    output logic                exc_addr_we,
    output logic [ADDR_W-1:0]   exc_addr_wdata,
    output logic                exc_sum_we,
    output logic [SUM_W-1:0]    exc_sum_wdata,
    output logic                pc_we,
    output logic [ADDR_W-1:0]   pc_wdata,
    output logic                ipl_we,
    output logic [IPL_W-1:0]    ipl_wdata,
    output logic                mode_we,
    output logic [MODE_W-1:0]   mode_wdata,
    output logic                shadow_set,
    output logic                flush
);

    logic              gate_ok;
    logic              capture;
    logic              enter;
    logic              pend;

    reason_e           lat_reason;
    logic [ADDR_W-1:0] lat_vector;
    logic [ADDR_W-1:0] lat_fault_pc;
    logic [FUNC_W-1:0] lat_func;
    logic              lat_arith;
    logic [SUM_W-1:0]  lat_sum;
    logic [ADDR_W-1:0] marked_pc;

    exc_gate u_gate (
        .hi_pri_pending (hi_pri_pending),
        .barrier_active (barrier_active),
        .pipe_safe      (pipe_safe),
        .at_writeback   (at_writeback),
        .gate_ok        (gate_ok)
    );

    exc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .gate_ok   (gate_ok),
        .capture   (capture),
        .enter     (enter),
        .pending   (pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_reason   <= RSN_CALL;
            lat_vector   <= '0;
            lat_fault_pc <= '0;
            lat_func     <= '0;
            lat_arith    <= 1'b0;
            lat_sum      <= '0;
        end else if (capture) begin
            lat_reason   <= reason_e'(req_reason);
            lat_vector   <= req_vector;
            lat_fault_pc <= req_fault_pc;
            lat_func     <= req_func;
            lat_arith    <= req_arith;
            lat_sum      <= req_sum;
        end
    end

    exc_target #(
        .ADDR_W    (ADDR_W),
        .FUNC_W    (FUNC_W),
        .OFS_SHIFT (OFS_SHIFT)
    ) u_target (
        .reason    (lat_reason),
        .vector    (lat_vector),
        .func      (lat_func),
        .base      (priv_base),
        .marked_pc (marked_pc)
    );

    always_comb begin
        ctx_save       = enter;
        exc_addr_we    = enter;
        exc_addr_wdata = lat_fault_pc;
        pc_we          = enter;
        pc_wdata       = marked_pc;
        ipl_we         = enter;
        ipl_wdata      = IPL_W'(IPL_MASK_ALL);
        mode_we        = enter;
        mode_wdata     = MODE_W'(MODE_KERNEL);
        shadow_set     = enter && (lat_reason == RSN_CALL);
        exc_sum_we     = enter && (lat_reason == RSN_TRAP) && lat_arith;
        exc_sum_wdata  = lat_sum;
        flush          = enter;
    end

    AST_SUM_EXCLUDES_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        exc_sum_we |-> !shadow_set); // R9
    AST_HELD_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && $past(pend)) |-> ($stable(lat_fault_pc) && $stable(lat_vector))); // R3
    AST_COMMIT_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_save |-> $past(pend)); // R2

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

    typedef struct {
        int          cyc;
        logic [63:0] pc;
        logic [63:0] addr;
        logic        sum_we;
        logic [7:0]  sum;
        logic        shadow;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_reason = 2'b00;
    logic [63:0] req_vector = '0;
    logic [63:0] req_fault_pc = '0;
    logic [7:0]  req_func = '0;
    logic        req_arith = 1'b0;
    logic [7:0]  req_sum = '0;
    logic        hi_pri_pending = 1'b0;
    logic        barrier_active = 1'b0;
    logic        pipe_safe = 1'b1;
    logic        at_writeback = 1'b1;
    logic [63:0] priv_base = 64'h0000_0000_2000_0000;

    logic        ctx_save, exc_addr_we, exc_sum_we, pc_we, ipl_we, mode_we, shadow_set, flush;
    logic [63:0] exc_addr_wdata, pc_wdata;
    logic [7:0]  exc_sum_wdata;
    logic [4:0]  ipl_wdata;
    logic [1:0]  mode_wdata;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic prev_save = 1'b0;
    exp_t q[$];

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reason(req_reason),
        .req_vector(req_vector), .req_fault_pc(req_fault_pc), .req_func(req_func),
        .req_arith(req_arith), .req_sum(req_sum), .hi_pri_pending(hi_pri_pending),
        .barrier_active(barrier_active), .pipe_safe(pipe_safe), .at_writeback(at_writeback),
        .priv_base(priv_base), .ctx_save(ctx_save), .exc_addr_we(exc_addr_we),
        .exc_addr_wdata(exc_addr_wdata), .exc_sum_we(exc_sum_we), .exc_sum_wdata(exc_sum_wdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .ipl_we(ipl_we), .ipl_wdata(ipl_wdata),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .shadow_set(shadow_set), .flush(flush)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic any_strobe();
        return ctx_save | flush | pc_we | ipl_we | mode_we | exc_addr_we | exc_sum_we | shadow_set;
    endfunction

    // which: 0 none, 1 higher priority, 2 barrier, 3 unsafe, 4 not at writeback
    task automatic set_gates(input int which);
        hi_pri_pending = (which == 1);
        barrier_active = (which == 2);
        pipe_safe      = (which != 3);
        at_writeback   = (which != 4);
    endtask

    // Driver: issues one request and pushes the expected commit into the scoreboard
    task automatic deliver(input logic [1:0] rsn, input logic [63:0] vec, input logic [63:0] fpc,
                           input logic [7:0] fn, input logic ar, input logic [7:0] sm,
                           input int nblk, input int which);
        exp_t e;
        @(negedge clk);
        set_gates(nblk > 0 ? which : 0);
        req_reason = rsn; req_vector = vec; req_fault_pc = fpc;
        req_func = fn; req_arith = ar; req_sum = sm; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < nblk; i++) begin
            chk("R3 blocked strobes", {63'd0, any_strobe()}, 64'd0);
            if (i == 0) begin
                req_valid = 1'b1; req_vector = ~vec; req_fault_pc = 64'hDEAD_0000;
                req_reason = 2'b00; req_func = 8'h11;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        set_gates(0);
        e.cyc    = cyc + 1;
        e.pc     = ((rsn == 2'b00) ? (priv_base + ({56'd0, fn} << 6)) : vec) | 64'd1;
        e.addr   = fpc;
        e.sum_we = (rsn == 2'b01) && ar;
        e.sum    = sm;
        e.shadow = (rsn == 2'b00);
        q.push_back(e);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops an expected commit whenever the context-save strobe appears
    always @(negedge clk) begin
        if (rst_n) begin
            checks = checks + 1;
            if ((ctx_save && prev_save) || (!ctx_save && any_strobe())) begin
                errors = errors + 1;
                $display("FAIL R10: strobes ctx=%0b prev=%0b others=%0b expected single aligned pulse",
                         ctx_save, prev_save, any_strobe());
            end
            if (ctx_save) begin
                if (q.size() == 0) begin
                    chk("R2 unexpected commit", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R11 commit cycle", 64'(e.cyc), 64'(cyc));
                    chk("R4/R5 new pc", pc_wdata, e.pc);
                    chk("R6 exception address", exc_addr_wdata, e.addr);
                    chk("R7 priority level", 64'(ipl_wdata), 64'd7);
                    chk("R7 mode", 64'(mode_wdata), 64'd0);
                    chk("R8 shadow", 64'(shadow_set), 64'(e.shadow));
                    chk("R9 summary write", 64'(exc_sum_we), 64'(e.sum_we));
                    if (e.sum_we) chk("R9 summary data", 64'(exc_sum_wdata), 64'(e.sum));
                    chk("R10 aligned enables",
                        {58'd0, flush, pc_we, ipl_we, mode_we, exc_addr_we, 1'b1}, 64'h3F);
                end
            end
            prev_save = ctx_save;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {63'd0, any_strobe()}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset idle", {63'd0, any_strobe()}, 64'd0);
        // R4 R8 R11: call with open gates
        deliver(2'b00, 64'h0, 64'h0000_0000_0001_1000, 8'h83, 1'b0, 8'h00, 0, 0);
        // R9 arithmetic trap, blocked by higher priority event
        deliver(2'b01, 64'h0000_0000_0000_4100, 64'h0000_0000_0001_2004, 8'h00, 1'b1, 8'h5A, 3, 1);
        // R9 non-arithmetic trap, blocked by barrier
        deliver(2'b01, 64'h0000_0000_0000_4200, 64'h0000_0000_0001_3008, 8'h00, 1'b0, 8'h33, 2, 2);
        // R5 interrupt with vector bit 0 already set, blocked by unsafe pipeline
        deliver(2'b10, 64'h0000_0000_0000_8001, 64'h0000_0000_0001_400C, 8'h00, 1'b0, 8'h00, 2, 3);
        // R5 fault, blocked by writeback; arith flag must not write summary
        deliver(2'b11, 64'h0000_0000_0000_C000, 64'h0000_0000_0001_5010, 8'h00, 1'b1, 8'h77, 4, 4);
        // R4 call with the largest function code
        deliver(2'b00, 64'h0, 64'hFFFF_FFFF_FFFF_FFFC, 8'hFF, 1'b0, 8'h00, 1, 1);
        // R4 call with function code zero
        deliver(2'b00, 64'h0, 64'h0000_0000_0000_0040, 8'h00, 1'b0, 8'h00, 0, 0);
        repeat (4) @(negedge clk);
        chk("R2 all requests committed", 64'(q.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule